// File: doc/BRIEF.md
# I2C SCL Programmable Clock Divider

This block turns an 8-bit frequency-select code into the serial-clock timing of an I2C master. The code is split into three fields: a prescale multiplier, a tap selector and a tap-pair selector. From these fields the block computes two values with a fixed formula. The first is the number of system clocks in one SCL period. The second is the hold count, which sets where SDA may change after SCL falls. A free-running counter then produces one-cycle strobes for the SCL falling edge, the SCL rising edge and the SDA hold point. A bus engine uses these strobes to drive its open-drain pads.

The code in use is copied from the input only at a period boundary, on a restart pulse, or while the block is idle. Changing the input code therefore never produces a shortened or stretched SCL period. The reserved prescale setting stops all strobes and raises an error flag until a valid code is applied.

Top module: `scl_clk_divider`

## Requirements
- R1: Code bits [2:0] select the SCL tap. Code values 0 to 7 give 5, 6, 7, 8, 9, 10, 12 and 15 clocks.
- R2: Code bits [5:3] select a pair (a, b). Values 0 to 7 give a = 5, 6, 6, 6, 6, 14, 30, 126 and b = 1, 2, 4, 8, 16, 32, 64, 128.
- R3: Code bits [7:6] select the prescale multiplier M. Value 0 gives 1, value 1 gives 2 and value 2 gives 4. Value 3 is reserved. While a reserved code is active, `config_error` is 1, `period_count` and `hold_count` are 0, and no strobe fires.
- R4: `period_count` equals M·(2a + (tap−1)·b + 2) for the active code.
- R5: `hold_count` equals M·(a + (tap−1)·b + 3) for the active code. Code 0x00 gives a period of 16 and a hold of 12.
- R6: While enabled with a valid code, `scl_fall` pulses once every `period_count` cycles and marks counter position 0.
- R7: `scl_rise` pulses floor(`period_count`/2) cycles after each `scl_fall`. At most one strobe is high in any cycle.
- R8: `sda_hold` pulses `hold_count` cycles after each `scl_fall`. This point always lies inside the period.
- R9: A change of `freq_code` while running takes effect only in the cycle after the last position of the current period. Until then `period_count` keeps its old value.
- R10: A `restart` pulse while enabled clears the counter and loads `freq_code`, so `scl_fall` fires in the next cycle. This also holds when the pulse coincides with the end of a period.
- R11: While `enable` is 0, no strobe fires. The counter is held at 0, and the active code follows `freq_code` with one cycle of delay.
- R12: After reset the active code is 0x00, `config_error` is 0, and with `enable` low no strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the divider when 1 |
| restart | input | 1 | One-cycle pulse: restart the period and load the code |
| freq_code | input | 8 | Frequency-select code |
| scl_fall | output | 1 | Strobe: drive SCL low |
| scl_rise | output | 1 | Strobe: release SCL high |
| sda_hold | output | 1 | Strobe: SDA may change now |
| period_count | output | 13 | Clocks per SCL period for the active code |
| hold_count | output | 13 | Clocks from SCL fall to the SDA change point |
| config_error | output | 1 | The active code uses the reserved multiplier |

## Verification
Two events can fall in the same cycle: a restart request and the natural end of a period, where the counter wraps and picks up the new code. The bench forces this collision by pulsing restart exactly one period after an earlier restart, with a different code on the input. A behavioural model, compared every clock, then expects position 0 and the newly presented code on the following cycle. The bench also changes the code in the middle of a period and checks that the old period and hold values stay in force up to the boundary.

// File: rtl/scl_div_pkg.sv
`timescale 1ns/1ps
package scl_div_pkg;

    localparam int CODE_W     = 8;
    localparam int TAP_W      = 4;
    localparam int S2T_W      = 7;
    localparam int T2T_W      = 8;
    localparam int MAX_PERIOD = 4 * (2 * 126 + 14 * 128 + 2);
    localparam int PW         = $clog2(MAX_PERIOD + 1);
    localparam logic [1:0] PRE_RESERVED = 2'b11;

    typedef struct packed {
        logic [1:0] pre;
        logic [2:0] grp;
        logic [2:0] tap;
    } code_fields_t;

    typedef struct packed {
        logic [PW-1:0] period;
        logic [PW-1:0] hold;
        logic          err;
    } timing_t;

    function automatic logic [TAP_W-1:0] tap_clocks(input logic [2:0] sel);
        case (sel)
            3'd0:    return 4'd5;
            3'd1:    return 4'd6;
            3'd2:    return 4'd7;
            3'd3:    return 4'd8;
            3'd4:    return 4'd9;
            3'd5:    return 4'd10;
            3'd6:    return 4'd12;
            default: return 4'd15;
        endcase
    endfunction

    function automatic logic [S2T_W-1:0] lead_clocks(input logic [2:0] sel);
        case (sel)
            3'd0:    return 7'd5;
            3'd5:    return 7'd14;
            3'd6:    return 7'd30;
            3'd7:    return 7'd126;
            default: return 7'd6;
        endcase
    endfunction

    function automatic logic [T2T_W-1:0] step_clocks(input logic [2:0] sel);
        return T2T_W'(1) << sel;
    endfunction

endpackage

// File: rtl/scl_div_decode.sv
`timescale 1ns/1ps
module scl_div_decode
    import scl_div_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output timing_t           tm
);
    code_fields_t      f;
    logic [PW-1:0]     lead;
    logic [PW-1:0]     span;
    logic [PW-1:0]     base_period;
    logic [PW-1:0]     base_hold;

    always_comb begin
        f           = code_fields_t'(code);
        lead        = PW'(lead_clocks(f.grp));
        span        = PW'(tap_clocks(f.tap) - 4'd1) * PW'(step_clocks(f.grp));
        base_period = (lead << 1) + span + PW'(2);
        base_hold   = lead + span + PW'(3);
        if (f.pre == PRE_RESERVED) begin
            tm.err    = 1'b1;
            tm.period = '0;
            tm.hold   = '0;
        end else begin
            tm.err    = 1'b0;
            tm.period = base_period << f.pre;
            tm.hold   = base_hold << f.pre;
        end
    end
endmodule

// File: rtl/scl_div_counter.sv
`timescale 1ns/1ps
module scl_div_counter
    import scl_div_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    enable,
    input  logic    restart,
    input  timing_t tm,
    output logic    load,
    output logic    scl_fall,
    output logic    scl_rise,
    output logic    sda_hold
);
    logic [PW-1:0] cnt_q;
    logic          at_end;
    logic          live;

    always_comb begin
        at_end   = (cnt_q == tm.period - PW'(1));
        load     = !enable || tm.err || restart || at_end;
        live     = enable && !tm.err;
        scl_fall = live && (cnt_q == '0);
        scl_rise = live && (cnt_q == (tm.period >> 1));
        sda_hold = live && (cnt_q == tm.hold);
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= '0;
        else           cnt_q <= cnt_q + PW'(1);
    end
endmodule

// File: rtl/scl_clk_divider.sv
`timescale 1ns/1ps
module scl_clk_divider
    import scl_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              restart,
    input  logic [CODE_W-1:0] freq_code,
    output logic              scl_fall,
    output logic              scl_rise,
    output logic              sda_hold,
    output logic [PW-1:0]     period_count,
    output logic [PW-1:0]     hold_count,
    output logic              config_error
);
    logic [CODE_W-1:0] act_code_q;
    timing_t           tm;
    logic              load;

    scl_div_decode u_decode (
        .code (act_code_q),
        .tm   (tm)
    );

    scl_div_counter u_counter (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .restart  (restart),
        .tm       (tm),
        .load     (load),
        .scl_fall (scl_fall),
        .scl_rise (scl_rise),
        .sda_hold (sda_hold)
    );

    always_ff @(posedge clk) begin
        if (rst)       act_code_q <= '0;
        else if (load) act_code_q <= freq_code;
    end

    assign period_count = tm.period;
    assign hold_count   = tm.hold;
    assign config_error = tm.err;
endmodule

// File: rtl/scl_div_checker.sv
`timescale 1ns/1ps
module scl_div_checker
    import scl_div_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          enable,
    input logic          restart,
    input logic          scl_fall,
    input logic          scl_rise,
    input logic          sda_hold,
    input logic [PW-1:0] period_count,
    input logic [PW-1:0] hold_count,
    input logic          config_error
);
    assert_reserved_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        config_error |-> !(scl_fall || scl_rise || sda_hold));

    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({scl_fall, scl_rise, sda_hold}));

    assert_hold_inside_R8: assert property (@(posedge clk) disable iff (rst)
        !config_error |-> (hold_count < period_count && hold_count > (period_count >> 1)));

    assert_code_at_boundary_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(period_count) |->
            (scl_fall || !enable || !$past(enable) || $past(restart) || $past(config_error)));

    assert_restart_fall_R10: assert property (@(posedge clk) disable iff (rst)
        (restart && enable && !config_error) |=> (scl_fall || !enable || config_error));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !(scl_fall || scl_rise || sda_hold));
endmodule

bind scl_clk_divider scl_div_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .restart      (restart),
    .scl_fall     (scl_fall),
    .scl_rise     (scl_rise),
    .sda_hold     (sda_hold),
    .period_count (period_count),
    .hold_count   (hold_count),
    .config_error (config_error)
);

// File: tb/tb_scl_clk_divider.sv
`timescale 1ns/1ps
module tb_scl_clk_divider;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        restart = 1'b0;
    logic [7:0]  freq_code = 8'h00;
    logic        scl_fall, scl_rise, sda_hold, config_error;
    logic [12:0] period_count, hold_count;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;
    int m_act = 0;
    int m_cnt = 0;

    always #10 clk = ~clk;

    scl_clk_divider dut (
        .clk(clk), .rst(rst), .enable(enable), .restart(restart),
        .freq_code(freq_code), .scl_fall(scl_fall), .scl_rise(scl_rise),
        .sda_hold(sda_hold), .period_count(period_count),
        .hold_count(hold_count), .config_error(config_error)
    );

    function automatic bit m_err(int c);
        return ((c / 64) % 4) == 3;
    endfunction

    function automatic int m_tap(int c);
        case (c % 8)
            0: return 5;  1: return 6;  2: return 7;  3: return 8;
            4: return 9;  5: return 10; 6: return 12; default: return 15;
        endcase
    endfunction

    function automatic int m_a(int c);
        case ((c / 8) % 8)
            0: return 5; 5: return 14; 6: return 30; 7: return 126;
            default: return 6;
        endcase
    endfunction

    function automatic int m_mul(int c);
        return 1 << ((c / 64) % 4);
    endfunction

    function automatic int m_period(int c);
        if (m_err(c)) return 0;
        return m_mul(c) * (2 * m_a(c) + (m_tap(c) - 1) * (1 << ((c / 8) % 8)) + 2);
    endfunction

    function automatic int m_hold(int c);
        if (m_err(c)) return 0;
        return m_mul(c) * (m_a(c) + (m_tap(c) - 1) * (1 << ((c / 8) % 8)) + 3);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_act <= 0; m_cnt <= 0;
        end else if (!enable || m_err(m_act) || restart) begin
            m_act <= int'(freq_code); m_cnt <= 0;
        end else if (m_cnt == m_period(m_act) - 1) begin
            m_act <= int'(freq_code); m_cnt <= 0;
        end else begin
            m_cnt <= m_cnt + 1;
        end
    end

    // cycle compare on the falling edge
    always @(negedge clk) begin
        if (chk_on) begin
            bit live;
            int p;
            live = enable && !m_err(m_act);
            p = m_period(m_act);
            chk("R3 config_error", int'(config_error), int'(m_err(m_act)));
            chk("R1/R2/R4 period_count", int'(period_count), p);
            chk("R5 hold_count", int'(hold_count), m_hold(m_act));
            chk("R6/R11 scl_fall", int'(scl_fall), int'(live && m_cnt == 0));
            chk("R7 scl_rise", int'(scl_rise), int'(live && m_cnt == p / 2));
            chk("R8 sda_hold", int'(sda_hold), int'(live && m_cnt == m_hold(m_act)));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_restart();
        @(posedge clk); #2 restart = 1'b1;
        @(posedge clk); #2 restart = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        chk_on = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 reset period", int'(period_count), 16);
        chk("R12 reset error", int'(config_error), 0);
        chk("R12 reset strobes", int'({scl_fall, scl_rise, sda_hold}), 0);

        // R5 code 0x00 running
        cyc(1); enable = 1'b1;
        cyc(40);
        chk("R5 code00 period", int'(period_count), 16);
        chk("R5 code00 hold", int'(hold_count), 12);

        // R10 restart aligns, R9 mid-period change
        pulse_restart();
        @(negedge clk);
        chk("R10 fall after restart", int'(scl_fall), 1);
        freq_code = 8'h01;
        cyc(15);
        @(negedge clk);
        chk("R9 old period kept", int'(period_count), 16);
        cyc(1);
        @(negedge clk);
        chk("R9 new period", int'(period_count), 17);

        // R10 restart colliding with period end
        freq_code = 8'h12;
        pulse_restart();
        freq_code = 8'h4B;
        cyc(m_period(8'h12) - 2);
        pulse_restart();
        @(negedge clk);
        chk("R10 collide fall", int'(scl_fall), 1);
        chk("R10 collide code", int'(period_count), m_period(8'h4B));
        cyc(3 * m_period(8'h4B));

        // R3 reserved multiplier
        freq_code = 8'hC0;
        pulse_restart();
        cyc(20);
        @(negedge clk);
        chk("R3 reserved flag", int'(config_error), 1);
        chk("R3 reserved period", int'(period_count), 0);
        freq_code = 8'h2D;
        cyc(3 * m_period(8'h2D));

        // R11 disable mid-run
        cyc(7); enable = 1'b0;
        cyc(30);
        @(negedge clk);
        chk("R11 idle strobes", int'({scl_fall, scl_rise, sda_hold}), 0);

        // R1 R2 R4 R5 decode sweep while idle
        for (int c = 0; c < 256; c++) begin
            freq_code = 8'(c);
            cyc(2);
        end

        // long periods
        enable = 1'b1;
        freq_code = 8'hBF;
        pulse_restart();
        cyc(2 * 8184 + 5);
        freq_code = 8'h7E;
        cyc(2 * m_period(8'h7E) + 8200);
        freq_code = 8'h36;
        cyc(4 * m_period(8'h36) + 3);
        finish_run();
    end
endmodule